// File: doc/BRIEF.md
# Bus Chip-Select Decoder

This block turns the upper address bits, the address strobe and the function-code lines of a 68000-style bus into a set of active-low select lines. It also produces a synchronous-peripheral request, the signal that tells the processor to finish the cycle with the slow peripheral handshake. Each select covers a fixed region of the memory map. The regions are non-volatile memory, a general I/O page, video memory, a slow I/O page, a video buffer enable and a wider video-data window.

The block is purely combinational. Each output depends only on the present inputs, and none of them can go low unless the address strobe is low. The video-data window ignores the two lowest decoded address bits, so it overlaps both the non-volatile memory page and the I/O page. The peripheral request goes low in two cases: during interrupt-acknowledge cycles, and for any access to the slow I/O page.

Top module: `bus_cs_decoder`

## Requirements
- R1: While `strobe_n` is 1, every output is 1, whatever the address and function code.
- R2: `nvm_sel_n` is 0 exactly when `strobe_n` is 0 and `addr_hi` (bit 5 = A23 … bit 0 = A18) equals 6'b100100.
- R3: `iopg_sel_n` is 0 exactly when `strobe_n` is 0 and `addr_hi` equals 6'b100101.
- R4: `vram_sel_n` is 0 exactly when `strobe_n` is 0 and `addr_hi` equals 6'b100000.
- R5: `slowio_sel_n` is 0 exactly when `strobe_n` is 0 and `addr_hi` equals 6'b100001.
- R6: `vbuf_oe_n` is 0 exactly when `strobe_n` is 0 and `addr_hi` equals 6'b101000.
- R7: `vdat_sel_n` is 0 exactly when `strobe_n` is 0 and `addr_hi[5:2]` equals 4'b1001. Bits 1 and 0 are ignored, so this select is active whenever `nvm_sel_n` or `iopg_sel_n` is active.
- R8: `periph_sync_n` is 0 when `strobe_n` is 0 and `fc` equals 3'b111 (interrupt acknowledge), for any address.
- R9: `periph_sync_n` is also 0 when `strobe_n` is 0 and `addr_hi` equals 6'b100001, for any function code. In every other case it is 1.
- R10: When `addr_hi` matches none of the windows in R2–R7, all six selects stay 1.
- R11: At most one of the five exact-page selects (R2–R6) is 0 at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| strobe_n | input | 1 | Address strobe, active low |
| addr_hi | input | 6 | Address bits A23 (bit 5) down to A18 (bit 0) |
| fc | input | 3 | Function-code lines |
| nvm_sel_n | output | 1 | Non-volatile memory select |
| iopg_sel_n | output | 1 | General I/O page select |
| vram_sel_n | output | 1 | Video memory select |
| slowio_sel_n | output | 1 | Slow I/O page select |
| vbuf_oe_n | output | 1 | Video buffer enable |
| vdat_sel_n | output | 1 | Video-data window select |
| periph_sync_n | output | 1 | Synchronous-peripheral request |

## Verification
The bench steps through all 1024 combinations of strobe, the six address bits and the three function-code bits. It compares every output against an integer-arithmetic model on every cycle. Sweeping the strobe separates gating faults from decode faults. Sweeping the two low address bits under the 4'b1001 prefix separates the exact pages from the wide video-data window. Sweeping the function code over the slow I/O page and over unmapped addresses shows that the two causes of the peripheral request are ORed rather than each requiring the other.

// File: rtl/cs_dec_pkg.sv
package cs_dec_pkg;

   localparam int DEC_W = 6;
   localparam int FC_W  = 3;
   localparam int N_WIN = 6;

   typedef enum int {
      W_NVM  = 0,
      W_IOPG = 1,
      W_VRAM = 2,
      W_SLOW = 3,
      W_VBUF = 4,
      W_VDAT = 5
   } win_e;

   typedef struct packed {
      logic [DEC_W-1:0] val;
      logic [DEC_W-1:0] care;
   } win_t;

   // Fixed map: value and care mask per window (bit 5 = A23)
   function automatic win_t win_of(input int idx);
      win_t w;
      case (idx)
         W_NVM:   begin w.val = 6'b100100; w.care = 6'b111111; end
         W_IOPG:  begin w.val = 6'b100101; w.care = 6'b111111; end
         W_VRAM:  begin w.val = 6'b100000; w.care = 6'b111111; end
         W_SLOW:  begin w.val = 6'b100001; w.care = 6'b111111; end
         W_VBUF:  begin w.val = 6'b101000; w.care = 6'b111111; end
         default: begin w.val = 6'b100100; w.care = 6'b111100; end
      endcase
      return w;
   endfunction

endpackage

// File: rtl/cs_win_match.sv
module cs_win_match #(
   parameter int               W      = 6,
   parameter logic [W-1:0]     VAL    = '0,
   parameter logic [W-1:0]     CARE   = '1,
   parameter int               IMPL   = 0
) (
   input  logic [W-1:0] addr,
   output logic         hit
);

   if (W < 1) begin : g_bad_w
      $error("cs_win_match: W must be at least 1");
   end
   if (IMPL != 0 && IMPL != 1) begin : g_bad_impl
      $error("cs_win_match: IMPL must be 0 or 1");
   end
   if ((VAL & ~CARE) != '0) begin : g_bad_val
      $error("cs_win_match: VAL has bits outside CARE");
   end

   if (IMPL == 0) begin : g_masked
      // Single masked compare
      assign hit = ((addr ^ VAL) & CARE) == '0;
   end else begin : g_terms
      // One literal per bit, ANDed as a product term
      logic [W-1:0] lit;
      for (genvar b = 0; b < W; b++) begin : g_bit
         if (!CARE[b]) begin : g_dc
            assign lit[b] = 1'b1;
         end else if (VAL[b]) begin : g_true
            assign lit[b] = addr[b];
         end else begin : g_comp
            assign lit[b] = ~addr[b];
         end
      end
      assign hit = &lit;
   end

endmodule

// File: rtl/cs_iack_detect.sv
module cs_iack_detect #(
   parameter int              FC_W      = 3,
   parameter logic [FC_W-1:0] IACK_CODE = '1
) (
   input  logic [FC_W-1:0] fc,
   output logic            iack
);

   if (FC_W < 1) begin : g_bad_fc
      $error("cs_iack_detect: FC_W must be at least 1");
   end

   assign iack = (fc == IACK_CODE);

endmodule

// File: rtl/cs_out_gate.sv
module cs_out_gate #(
   parameter int N = 7
) (
   input  logic         strobe_n,
   input  logic [N-1:0] hit,
   output logic [N-1:0] sel_n
);

   if (N < 1) begin : g_bad_n
      $error("cs_out_gate: N must be at least 1");
   end

   for (genvar i = 0; i < N; i++) begin : g_gate
      assign sel_n[i] = ~(hit[i] & ~strobe_n);
   end

   always_comb begin
      if (strobe_n) begin
         AST_STROBE_IDLE: assert (&sel_n); // R1
      end
   end

endmodule

// File: rtl/bus_cs_decoder.sv
module bus_cs_decoder
   import cs_dec_pkg::*;
#(
   parameter int                MATCH_IMPL = 0,
   parameter logic [FC_W-1:0]   IACK_CODE  = 3'b111
) (
   input  logic             strobe_n,
   input  logic [DEC_W-1:0] addr_hi,
   input  logic [FC_W-1:0]  fc,
   output logic             nvm_sel_n,
   output logic             iopg_sel_n,
   output logic             vram_sel_n,
   output logic             slowio_sel_n,
   output logic             vbuf_oe_n,
   output logic             vdat_sel_n,
   output logic             periph_sync_n
);

   localparam int N_OUT   = N_WIN + 1;
   localparam int O_SYNC  = N_WIN;

   if (DEC_W != 6) begin : g_bad_dec
      $error("bus_cs_decoder: map is defined for six decoded bits");
   end

   logic [N_WIN-1:0] win_hit;
   logic             iack;
   logic [N_OUT-1:0] any_hit;
   logic [N_OUT-1:0] out_n;

   for (genvar k = 0; k < N_WIN; k++) begin : g_win
      localparam win_t WK = win_of(k);
      cs_win_match #(
         .W    (DEC_W),
         .VAL  (WK.val),
         .CARE (WK.care),
         .IMPL (MATCH_IMPL)
      ) u_match (
         .addr (addr_hi),
         .hit  (win_hit[k])
      );
   end

   cs_iack_detect #(
      .FC_W      (FC_W),
      .IACK_CODE (IACK_CODE)
   ) u_iack (
      .fc   (fc),
      .iack (iack)
   );

   always_comb begin
      any_hit              = '0;
      any_hit[N_WIN-1:0]   = win_hit;
      any_hit[O_SYNC]      = iack | win_hit[W_SLOW];
   end

   cs_out_gate #(.N(N_OUT)) u_gate (
      .strobe_n (strobe_n),
      .hit      (any_hit),
      .sel_n    (out_n)
   );

   assign nvm_sel_n     = out_n[W_NVM];
   assign iopg_sel_n    = out_n[W_IOPG];
   assign vram_sel_n    = out_n[W_VRAM];
   assign slowio_sel_n  = out_n[W_SLOW];
   assign vbuf_oe_n     = out_n[W_VBUF];
   assign vdat_sel_n    = out_n[W_VDAT];
   assign periph_sync_n = out_n[O_SYNC];

   always_comb begin
      AST_PAGES_EXCL: assert ($countones({~nvm_sel_n, ~iopg_sel_n, ~vram_sel_n,
                                          ~slowio_sel_n, ~vbuf_oe_n}) <= 1); // R11
      AST_VDAT_OVERLAP: assert (!(!nvm_sel_n || !iopg_sel_n) || !vdat_sel_n); // R7
      AST_SLOW_SYNC: assert (slowio_sel_n || !periph_sync_n); // R9
      AST_LOW_HALF_IDLE: assert (addr_hi[DEC_W-1] ||
                                 (&{nvm_sel_n, iopg_sel_n, vram_sel_n,
                                    slowio_sel_n, vbuf_oe_n, vdat_sel_n})); // R10
   end

endmodule

// File: tb/tb_bus_cs_decoder.sv
module tb_bus_cs_decoder;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       strobe_n = 1'b1;
   logic [5:0] addr_hi = '0;
   logic [2:0] fc = '0;
   logic nvm_sel_n, iopg_sel_n, vram_sel_n, slowio_sel_n, vbuf_oe_n, vdat_sel_n, periph_sync_n;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   bus_cs_decoder dut (
      .strobe_n      (strobe_n),
      .addr_hi       (addr_hi),
      .fc            (fc),
      .nvm_sel_n     (nvm_sel_n),
      .iopg_sel_n    (iopg_sel_n),
      .vram_sel_n    (vram_sel_n),
      .slowio_sel_n  (slowio_sel_n),
      .vbuf_oe_n     (vbuf_oe_n),
      .vdat_sel_n    (vdat_sel_n),
      .periph_sync_n (periph_sync_n)
   );

   task automatic check(input string tag, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: as=%0b addr=%06b fc=%03b actual=%0b expected=%0b",
                  tag, strobe_n, addr_hi, fc, act, exp);
      end
   endtask

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   // Behavioural model: integer compares, one per window
   task automatic compare();
      int a, f, hits;
      bit act, e_nvm, e_io, e_vr, e_sl, e_vb, e_vd, e_sy;
      a   = int'(addr_hi);
      f   = int'(fc);
      act = (strobe_n == 1'b0);
      e_nvm = !(act && a == 36);
      e_io  = !(act && a == 37);
      e_vr  = !(act && a == 32);
      e_sl  = !(act && a == 33);
      e_vb  = !(act && a == 40);
      e_vd  = !(act && (a / 4) == 9);
      e_sy  = !(act && (f == 7 || a == 33));
      if (!act) begin
         check("R1 idle", &{nvm_sel_n, iopg_sel_n, vram_sel_n, slowio_sel_n,
                            vbuf_oe_n, vdat_sel_n, periph_sync_n}, 1'b1);
      end
      check("R2 nvm", nvm_sel_n, e_nvm);
      check("R3 iopg", iopg_sel_n, e_io);
      check("R4 vram", vram_sel_n, e_vr);
      check("R5 slowio", slowio_sel_n, e_sl);
      check("R6 vbuf", vbuf_oe_n, e_vb);
      check("R7 vdat", vdat_sel_n, e_vd);
      if (a == 33) check("R9 sync", periph_sync_n, e_sy);
      else         check("R8 sync", periph_sync_n, e_sy);
      if (!(a inside {32, 33, 36, 37, 38, 39, 40})) begin
         check("R10 unmapped", &{nvm_sel_n, iopg_sel_n, vram_sel_n, slowio_sel_n,
                                 vbuf_oe_n, vdat_sel_n}, 1'b1);
      end
      hits = 0;
      if (!nvm_sel_n)    hits++;
      if (!iopg_sel_n)   hits++;
      if (!vram_sel_n)   hits++;
      if (!slowio_sel_n) hits++;
      if (!vbuf_oe_n)    hits++;
      check("R11 exclusive", hits <= 1, 1'b1);
   endtask

   // Compare on every clock, away from the driving edge
   always @(negedge clk) begin
      if (!done) compare();
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      for (int v = 0; v < 1024; v++) begin
         @(posedge clk);
         #1;
         strobe_n = v[9];
         addr_hi  = v[8:3];
         fc       = v[2:0];
      end
      @(posedge clk);
      #1 strobe_n = 1'b1;
      @(negedge clk);
      @(posedge clk);
      done = 1'b1;
      summary();
   end

   initial begin
      while (cycles < 100000) begin
         @(posedge clk);
         cycles++;
      end
      done = 1'b1;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      summary();
   end

endmodule